// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a half-duplex synchronous serial link and generates the shift clock itself. A clock-enable input marks each oscillator period (one "tick"). Every bit occupies a cell of twelve ticks. The shift clock is low for the first ten ticks of the cell and high for the last two. The block places each outgoing bit at the start of its cell and samples incoming data at the moment the shift clock rises.

A write to the transmit byte starts a transmit, in which the block drives the data line. Asserting the receive request starts a receive, in which the data line is released and only sampled. When the eighth cell ends, the block raises a one-clock completion pulse and returns to idle with the shift clock parked high. While a transfer runs, the busy output stays high and the block ignores new requests.

Top module: `sser_sync_shifter`

## Requirements
- R1: After reset, `sclk` is 1, `sd_oe` is 0, `sd_out` is 1, `busy` is 0, `done` is 0 and `rx_data` is 0x00.
- R2: A `tx_wr` pulse while idle starts a transmit. On the next clock, `busy` is 1 and `sd_oe` is 1.
- R3: A transfer has exactly 8 bit cells (8 rising edges of `sclk`). Bits go out and come in least significant bit first: bit 0 is in the first cell and bit 7 in the last.
- R4: Consecutive rising edges of `sclk` within a transfer are exactly 12 ticks apart.
- R5: `sclk` is 0 for 10 ticks of each cell and 1 for the last 2. It is 1 whenever the block is idle.
- R6: In a transmit, `sd_out` changes exactly 2 ticks after a rising edge of `sclk`. It is stable for at least 10 ticks before each rising edge.
- R7: In a receive, `sd_in` is captured at the clock edge on which `sclk` rises, with no hold time after it. `rx_data` is loaded with the assembled byte (first bit in bit 0) when `done` pulses.
- R8: `sd_oe` is 1 only during a transmit. It is 0 during a receive and while idle.
- R9: `done` is a single-clock pulse that follows the end of the eighth cell. `busy` falls on the same edge that raises `done`.
- R10: `tx_wr` and `rx_en` are ignored while `busy` is 1. They change neither the byte in flight nor start a later transfer.
- R11: If `tx_wr` and `rx_en` are both asserted while idle, a transmit starts and the receive request is dropped.
- R12: All timing counts ticks (`osc_en` high), not clocks. With `osc_en` low, `sclk` and `sd_out` hold their values.
- R13: `rx_data` changes only at the end of a receive. A transmit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-clock enable per oscillator period (tick) |
| tx_data | input | 8 | Byte to transmit, sampled when `tx_wr` is high |
| tx_wr | input | 1 | Write strobe that starts a transmit |
| rx_en | input | 1 | Receive request, starts a receive when idle |
| rx_data | output | 8 | Last byte received |
| done | output | 1 | One-clock pulse at the end of a transfer |
| busy | output | 1 | A transfer is in progress |
| sd_out | output | 1 | Serial data driven onto the line |
| sd_oe | output | 1 | Output enable for `sd_out` |
| sd_in | input | 1 | Serial data read from the line |
| sclk | output | 1 | Generated shift clock |

## Verification
The bound checker watches the following on every cycle:
- the idle level of the shift clock;
- that the output enable is confined to busy periods;
- the single-cycle completion pulse and how it lines up with the busy flag;
- that outputs freeze while no tick arrives;
- that `rx_data` changes only together with `done`.

Bit order, the exact 12-tick cell, the 10-tick setup and 2-tick hold of outgoing data, and sampling with zero hold are shown only by the bench. It measures these in ticks against an independent slave model, with both a continuous and a sparse tick pattern. Whether requests made while busy are dropped, and whether transmit beats receive, can likewise be seen only in the bench's scenarios.

// File: rtl/sser_pkg.sv
package sser_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/sser_cell_timer.sv
// Tick counter inside one bit cell; flags the rising-edge tick and the last tick.
module sser_cell_timer #(
  parameter int CELL_TICKS = 12,
  parameter int RISE_PHASE = 10,
  localparam int PW = $clog2(CELL_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  output logic          rise_evt,
  output logic          end_evt,
  output logic [PW-1:0] phase
);
  logic step;

  assign step     = run && tick;
  assign rise_evt = step && (phase == PW'(RISE_PHASE - 1));
  assign end_evt  = step && (phase == PW'(CELL_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (step) begin
      if (phase == PW'(CELL_TICKS - 1)) phase <= '0;
      else                              phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/sser_bit_ctr.sv
// Counts completed bit cells of one transfer.
module sser_bit_ctr #(
  parameter int NBITS = 8,
  localparam int CW = (NBITS > 2) ? $clog2(NBITS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sser_shift_path.sv
// Transmit and receive shift registers; bit order selected by parameter.
module sser_shift_path #(
  parameter int W         = 8,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tx_step,
  input  logic         rx_step,
  input  logic         rx_bit,
  output logic         first_bit,
  output logic         next_bit,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_sr;
  logic [W-1:0] rx_sr;

  assign rx_word = rx_sr;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign first_bit = load_val[0];
      assign next_bit  = tx_sr[1];
      always_ff @(posedge clk) begin
        if (rst) begin
          tx_sr <= '0;
          rx_sr <= '0;
        end else begin
          if (load)         tx_sr <= load_val;
          else if (tx_step) tx_sr <= {1'b0, tx_sr[W-1:1]};
          if (rx_step)      rx_sr <= {rx_bit, rx_sr[W-1:1]};
        end
      end
    end else begin : g_msb
      assign first_bit = load_val[W-1];
      assign next_bit  = tx_sr[W-2];
      always_ff @(posedge clk) begin
        if (rst) begin
          tx_sr <= '0;
          rx_sr <= '0;
        end else begin
          if (load)         tx_sr <= load_val;
          else if (tx_step) tx_sr <= {tx_sr[W-2:0], 1'b0};
          if (rx_step)      rx_sr <= {rx_sr[W-2:0], rx_bit};
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sser_sync_shifter.sv
// Half-duplex synchronous serial shifter with self-generated shift clock.
module sser_sync_shifter #(
  parameter int DATA_W     = 8,
  parameter int CELL_TICKS = 12,
  parameter int HOLD_TICKS = 2,
  parameter bit LSB_FIRST  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              busy,
  output logic              sd_out,
  output logic              sd_oe,
  input  logic              sd_in,
  output logic              sclk
);
  import sser_pkg::*;

  localparam int RISE_PHASE = CELL_TICKS - HOLD_TICKS;
  localparam int PW         = $clog2(CELL_TICKS);

  xfer_mode_e        mode;
  logic              idle;
  logic              start_tx;
  logic              start_rx;
  logic              start;
  logic              rise_evt;
  logic              end_evt;
  logic              last_bit;
  logic              first_bit;
  logic              next_bit;
  logic [DATA_W-1:0] rx_word;
  logic [PW-1:0]     phase;

  assign idle     = (mode == MODE_IDLE);
  assign start_tx = idle && tx_wr;
  assign start_rx = idle && !tx_wr && rx_en;
  assign start    = start_tx || start_rx;
  assign busy     = !idle;

  sser_cell_timer #(
    .CELL_TICKS(CELL_TICKS),
    .RISE_PHASE(RISE_PHASE)
  ) i_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (!idle),
    .restart (start),
    .tick    (osc_en),
    .rise_evt(rise_evt),
    .end_evt (end_evt),
    .phase   (phase)
  );

  sser_bit_ctr #(
    .NBITS(DATA_W)
  ) i_bits (
    .clk  (clk),
    .rst  (rst),
    .clear(start),
    .step (end_evt),
    .last (last_bit)
  );

  sser_shift_path #(
    .W        (DATA_W),
    .LSB_FIRST(LSB_FIRST)
  ) i_path (
    .clk      (clk),
    .rst      (rst),
    .load     (start_tx),
    .load_val (tx_data),
    .tx_step  (end_evt && !last_bit && (mode == MODE_TX)),
    .rx_step  (rise_evt && (mode == MODE_RX)),
    .rx_bit   (sd_in),
    .first_bit(first_bit),
    .next_bit (next_bit),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_IDLE;
      sclk    <= 1'b1;
      sd_out  <= 1'b1;
      sd_oe   <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (idle) begin
        if (start_tx) begin
          mode   <= MODE_TX;
          sclk   <= 1'b0;
          sd_out <= first_bit;
          sd_oe  <= 1'b1;
        end else if (start_rx) begin
          mode <= MODE_RX;
          sclk <= 1'b0;
        end
      end else begin
        if (rise_evt) sclk <= 1'b1;
        if (end_evt) begin
          if (last_bit) begin
            mode   <= MODE_IDLE;
            done   <= 1'b1;
            sd_oe  <= 1'b0;
            sd_out <= 1'b1;
            if (mode == MODE_RX) rx_data <= rx_word;
          end else begin
            sclk <= 1'b0;
            if (mode == MODE_TX) sd_out <= next_bit;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sser_sync_shifter_chk.sv
module sser_sync_shifter_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_en,
  input logic [7:0] rx_data,
  input logic       done,
  input logic       busy,
  input logic       sd_out,
  input logic       sd_oe,
  input logic       sclk
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk && !sd_oe)); // R5

  AST_OE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9

  AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy && !osc_en) |=> ($stable(sclk) && $stable(sd_out) && busy)); // R12

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $past(osc_en)); // R12

  AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && busy) |=> $stable(sd_out)); // R6

  AST_RXDATA_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> done); // R13
endmodule

bind sser_sync_shifter sser_sync_shifter_chk i_chk (
  .clk    (clk),
  .rst    (rst),
  .osc_en (osc_en),
  .rx_data(rx_data),
  .done   (done),
  .busy   (busy),
  .sd_out (sd_out),
  .sd_oe  (sd_oe),
  .sclk   (sclk)
);

// File: tb/test_sser_sync_shifter.sv
module test_sser_sync_shifter;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit         is_rx;
    logic [7:0] val;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_wr = 1'b0;
  logic       rx_en = 1'b0;
  logic       sd_in = 1'b0;
  logic [7:0] rx_data;
  logic       done, busy, sd_out, sd_oe, sclk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  sb_item_t   sbq[$];
  logic [7:0] rx_pat  = '0;
  logic [7:0] rx_keep = '0;
  int         osc_div = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sser_sync_shifter i_sser_sync_shifter (
    .clk(clk), .rst(rst), .osc_en(osc_en), .tx_data(tx_data), .tx_wr(tx_wr),
    .rx_en(rx_en), .rx_data(rx_data), .done(done), .busy(busy),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in), .sclk(sclk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  // Monitor, tick generator and receive slave, all on the falling edge.
  int unsigned ticks = 0, last_change = 0, last_rise = 0, last_fall = 0;
  int          rises = 0, rx_idx = 0, osc_cnt = 0, cycles = 0;
  logic        p_sclk = 1'b1, p_out = 1'b1, p_done = 1'b0, p_busy = 1'b0;
  logic [7:0]  txbits = '0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 0);
      finish_run();
    end
    if (!rst) begin
      if (osc_en) ticks++;
      if (busy && !p_busy) begin
        rises = 0;
        txbits = '0;
      end
      if (!sclk && p_sclk) last_fall = ticks;
      if (sd_out != p_out && busy) begin
        if (rises > 0) check(ticks - last_rise == 2, "R6 hold", ticks - last_rise, 2);
        last_change = ticks;
      end
      if (sclk && !p_sclk) begin
        check(ticks - last_fall == 10, "R5 low time", ticks - last_fall, 10);
        if (rises > 0) check(ticks - last_rise == 12, "R4 cell", ticks - last_rise, 12);
        if (sd_oe) begin
          check(ticks - last_change >= 10, "R6 setup", ticks - last_change, 10);
          if (rises < 8) txbits[rises] = sd_out;
        end
        last_rise = ticks;
        rises++;
        rx_idx = rises;
        sd_in  = (rx_idx < 8) ? rx_pat[rx_idx] : 1'b0; // R7: change right after rise
      end
      if (!busy || rises == 0) sd_in = rx_pat[0];
      if (busy && sbq.size() > 0)
        check(sd_oe == !sbq[0].is_rx, "R8 oe", sd_oe, !sbq[0].is_rx);
      if (!busy) check(sclk == 1'b1, "R5 idle sclk", sclk, 1);
      if (done && p_done) check(0, "R9 done width", 2, 1);
      if (done) begin
        check(!busy, "R9 busy with done", busy, 0);
        check(rises == 8, "R3 cell count", rises, 8);
        if (sbq.size() == 0) begin
          check(0, "R10 unexpected transfer", 1, 0);
        end else begin
          sb_item_t it;
          it = sbq.pop_front();
          if (it.is_rx) begin
            check(rx_data == it.val, "R7 rx byte", rx_data, it.val);
            rx_keep = it.val;
          end else begin
            check(txbits == it.val, "R3 tx bits", txbits, it.val);
            check(rx_data == rx_keep, "R13 rx kept", rx_data, rx_keep);
          end
        end
      end
    end
    p_sclk = sclk; p_out = sd_out; p_done = done; p_busy = busy;
    osc_en  = (osc_cnt == 0);
    osc_cnt = (osc_cnt + 1) % osc_div;
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v);
    sb_item_t it;
    it.is_rx = 0; it.val = v;
    @(negedge clk);
    tx_data = v; tx_wr = 1'b1;
    sbq.push_back(it);
    @(negedge clk);
    tx_wr = 1'b0;
    check(busy && sd_oe, "R2 start", {busy, sd_oe}, 2'b11);
  endtask

  task automatic recv(input logic [7:0] v);
    sb_item_t it;
    it.is_rx = 1; it.val = v;
    @(negedge clk);
    rx_pat = v; rx_en = 1'b1;
    sbq.push_back(it);
    @(negedge clk);
    rx_en = 1'b0;
    check(busy && !sd_oe, "R8 rx start", {busy, sd_oe}, 2'b10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sclk && !sd_oe && sd_out && !busy && !done, "R1 reset lines",
          {sclk, sd_oe, sd_out, busy, done}, 5'b10100);
    check(rx_data == 8'h00, "R1 reset rx_data", rx_data, 0);

    send(8'hA5); wait_done();
    send(8'h01); wait_done();   // R3 only bit 0 set
    send(8'h80); wait_done();   // R3 only bit 7 set
    recv(8'h3C); wait_done();   // R7
    recv(8'hC3); wait_done();
    send(8'h5A); wait_done();   // R13

    // R10: requests during a transfer are dropped
    send(8'h96);
    repeat (20) @(negedge clk);
    tx_data = 8'hFF; tx_wr = 1'b1; rx_en = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0; rx_en = 1'b0;
    wait_done();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 10 == 0) check(!busy && sclk, "R10 no restart", busy, 0);
    end

    // R11: transmit wins over receive
    begin
      sb_item_t it;
      it.is_rx = 0; it.val = 8'h0F;
      @(negedge clk);
      tx_data = 8'h0F; tx_wr = 1'b1; rx_en = 1'b1;
      sbq.push_back(it);
      @(negedge clk);
      tx_wr = 1'b0; rx_en = 1'b0;
      check(busy && sd_oe, "R11 tx priority", {busy, sd_oe}, 2'b11);
      wait_done();
    end

    // R12: sparse ticks
    osc_div = 3;
    repeat (6) @(negedge clk);
    send(8'hC9); wait_done();
    recv(8'h71); wait_done();
    osc_div = 5;
    repeat (6) @(negedge clk);
    send(8'h2E); wait_done();
    check(sbq.size() == 0, "R12 all transfers seen", sbq.size(), 0);
    finish_run();
  end
endmodule